// File: doc/BRIEF.md
# Speculative Narrow-Width Integer Execute Stage

This block is an integer execute stage with a byte-sliced register file. Software picks the datapath width ahead of time: 8, 16 or 32 bits. It does so with a configuration instruction placed at the start of each code region. In a narrow width, the execute latches and the ALU enable only their low byte slices. The register-file slices above the active width sit in a low-power retention state and keep their contents. A result written in a narrow width stores only its low slices, plus a per-register width tag. A later read rebuilds the full value by sign-extending from that tag.

The width choice is a guess. A check in execute compares every operand and result against the active width. When a value does not fit, the stage raises a flush request, drops the result and waits a parameterised penalty. It then replays the instruction at full 32-bit width. The stage stays at full width until software issues the next configuration instruction. An operand whose tag is wider than the narrow width needs the retained upper slices, so it costs a one-cycle wake-up stall before it is accepted. A one-entry write-back register forwards its value to the next instruction, and the write-back honours the slice width of the result it carries.

Top module: `nwExecTop`

## Requirements
- R1: After reset, the width is 32-bit (curMode 2), wbValid is 0, instReady is 1, sliceEn is 4'b1111 and rfDrowsy is 4'b0000. All registers read as zero.
- R2: An accepted instruction with instOp 7 sets the width from instCfg: 0 gives 8-bit (sliceEn 4'b0001), 1 gives 16-bit (4'b0011), and 2 or 3 give 32-bit (4'b1111). It produces no write-back in the next cycle.
- R3: rfDrowsy is the bitwise complement of sliceEn. The exception is the cycle after a wake-up stall, when it is 4'b0000.
- R4: The opcodes are 0 add, 1 subtract (rs1-rs2), 2 AND, 3 OR, 4 XOR, 5 load instImm, and 6 copy rs1, all 32-bit and wrapping. An instruction accepted in a cycle shows wbValid, wbRd and wbData in the next cycle. Its value is visible to a read in that same next cycle through forwarding, and from the register file after it.
- R5: A value fits width w when bits 31..w-1 are all equal. In a narrow width, an accepted instruction whose used operand or result does not fit raises flushReq in its accept cycle, and shows no write-back in the next cycle. Opcodes 0-4 use both operands, 6 uses rs1 only, and 5 uses none.
- R6: After a flush in cycle c, instReady is 0 in cycles c+1 to c+PENALTY. In cycle c+PENALTY+1, the full-width result appears on the write-back and instReady returns to 1.
- R7: After a flush, the width is 32-bit until the next accepted configuration instruction.
- R8: In a narrow width, a valid instruction whose used operand was last written at a wider width holds instReady at 0 for exactly one cycle, and is then accepted.
- R9: A value written in a narrow width reads back later, at any width, as its sign-extended 32-bit value.
- R10: In 32-bit width, flushReq is never raised.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| instValid | input | 1 | Instruction present |
| instOp | input | 3 | Opcode (7 = width configuration) |
| instRd | input | 4 | Destination register |
| instRs1 | input | 4 | First source register |
| instRs2 | input | 4 | Second source register |
| instImm | input | 32 | Immediate for opcode 5 |
| instCfg | input | 2 | Width code for opcode 7 |
| instReady | output | 1 | Instruction accepted this cycle when valid |
| flushReq | output | 1 | Mis-speculation detected on the accepted instruction |
| wbValid | output | 1 | Write-back valid |
| wbRd | output | 4 | Write-back register |
| wbData | output | 32 | Write-back value |
| sliceEn | output | 4 | Active byte slices of latches and ALU |
| rfDrowsy | output | 4 | Register-file slices in retention |
| curMode | output | 2 | Current width: 0 8-bit, 1 16-bit, 2 32-bit |

## Verification
On every cycle, the assertions check the local causal rules. A flush is followed by a stall, full width and no write-back. A configuration instruction leaves no write-back. The penalty counter stays in range. A wake-up admits the held instruction. A write-back value always fits its width tag. The exact penalty length, the values stored and rebuilt from narrow slices, forwarding across narrow and full writes, and the one-cycle wake cost on wide-tagged operands can only be shown by the bench's scenarios, compared cycle by cycle with the behavioural model.

// File: rtl/nw_pkg.sv
package nw_pkg;
  localparam int DATA_W  = 32;
  localparam int SLICE_W = 8;
  localparam int NSLICES = DATA_W / SLICE_W;

  typedef enum logic [1:0] {MODE8 = 2'd0, MODE16 = 2'd1, MODE32 = 2'd2} widthE;

  localparam logic [2:0] OP_ADD = 3'd0;
  localparam logic [2:0] OP_SUB = 3'd1;
  localparam logic [2:0] OP_AND = 3'd2;
  localparam logic [2:0] OP_OR  = 3'd3;
  localparam logic [2:0] OP_XOR = 3'd4;
  localparam logic [2:0] OP_IMM = 3'd5;
  localparam logic [2:0] OP_MOV = 3'd6;
  localparam logic [2:0] OP_CFG = 3'd7;

  typedef struct packed {
    logic  exWrite;
    logic  capture;
    logic  replayWrite;
    widthE mode;
  } strobeS;

  function automatic logic fitsW(logic [DATA_W-1:0] v, widthE m);
    case (m)
      MODE8:   fitsW = (&v[DATA_W-1:7])  | ~(|v[DATA_W-1:7]);
      MODE16:  fitsW = (&v[DATA_W-1:15]) | ~(|v[DATA_W-1:15]);
      default: fitsW = 1'b1;
    endcase
  endfunction

  function automatic logic [DATA_W-1:0] sextW(logic [DATA_W-1:0] v, widthE m);
    case (m)
      MODE8:   sextW = {{(DATA_W-8){v[7]}}, v[7:0]};
      MODE16:  sextW = {{(DATA_W-16){v[15]}}, v[15:0]};
      default: sextW = v;
    endcase
  endfunction

  function automatic logic [DATA_W-1:0] aluF(logic [2:0] op, logic [DATA_W-1:0] a,
                                             logic [DATA_W-1:0] b, logic [DATA_W-1:0] imm);
    case (op)
      OP_ADD:  aluF = a + b;
      OP_SUB:  aluF = a - b;
      OP_AND:  aluF = a & b;
      OP_OR:   aluF = a | b;
      OP_XOR:  aluF = a ^ b;
      OP_IMM:  aluF = imm;
      default: aluF = a;
    endcase
  endfunction
endpackage

// File: rtl/nwCtrl.sv
module nwCtrl
  import nw_pkg::*;
#(
  parameter int PENALTY = 5
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        instValid,
  input  logic [2:0]  instOp,
  input  logic [1:0]  instCfg,
  input  logic        fitsOk,
  input  logic        needUpper,
  output strobeS      strobes,
  output logic        instReady,
  output logic        flushReq,
  output logic [1:0]  curMode,
  output logic [NSLICES-1:0] sliceEn,
  output logic [NSLICES-1:0] rfDrowsy
);
  localparam int CNT_W = $clog2(PENALTY + 1);

  widthE            modeQ;
  logic             penQ;
  logic [CNT_W-1:0] cntQ;
  logic             wokeQ;

  logic isCfg, wakeNeed, accept, mis, lastPen;
  widthE cfgMode;

  always_comb begin
    isCfg    = (instOp == OP_CFG);
    wakeNeed = !penQ && instValid && !isCfg && (modeQ != MODE32) && needUpper && !wokeQ;
    instReady = !penQ && !wakeNeed;
    accept   = instValid && instReady;
    mis      = accept && !isCfg && (modeQ != MODE32) && !fitsOk;
    lastPen  = penQ && (cntQ == CNT_W'(1));
    case (instCfg)
      2'd0:    cfgMode = MODE8;
      2'd1:    cfgMode = MODE16;
      default: cfgMode = MODE32;
    endcase
    strobes.exWrite     = accept && !isCfg && !mis;
    strobes.capture     = mis;
    strobes.replayWrite = lastPen;
    strobes.mode        = modeQ;
    flushReq            = mis;
    curMode             = modeQ;
    case (modeQ)
      MODE8:   sliceEn = 4'b0001;
      MODE16:  sliceEn = 4'b0011;
      default: sliceEn = 4'b1111;
    endcase
    rfDrowsy = wokeQ ? '0 : ~sliceEn;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      modeQ <= MODE32;
      penQ  <= 1'b0;
      cntQ  <= '0;
      wokeQ <= 1'b0;
    end else begin
      if (mis) modeQ <= MODE32;
      else if (accept && isCfg) modeQ <= cfgMode;

      if (mis) begin
        penQ <= 1'b1;
        cntQ <= CNT_W'(PENALTY);
      end else if (lastPen) begin
        penQ <= 1'b0;
        cntQ <= '0;
      end else if (penQ) begin
        cntQ <= cntQ - CNT_W'(1);
      end

      if (accept) wokeQ <= 1'b0;
      else if (wakeNeed) wokeQ <= 1'b1;
    end
  end

  AST_FLUSH_STALL: assert property (@(posedge clk) disable iff (!rstN)
    flushReq |=> !instReady); // R6
  AST_FLUSH_FULL: assert property (@(posedge clk) disable iff (!rstN)
    flushReq |=> (curMode == 2'd2)); // R7
  AST_PEN_RANGE: assert property (@(posedge clk) disable iff (!rstN)
    penQ |-> (cntQ >= CNT_W'(1) && cntQ <= CNT_W'(PENALTY))); // R6
  AST_WAKE_ONCE: assert property (@(posedge clk) disable iff (!rstN)
    (wokeQ && instValid) |-> instReady); // R8
endmodule

// File: rtl/nwDatapath.sv
module nwDatapath
  import nw_pkg::*;
#(
  parameter int NREGS = 16,
  localparam int REG_AW = $clog2(NREGS)
) (
  input  logic              clk,
  input  logic              rstN,
  input  strobeS            strobes,
  input  logic [2:0]        instOp,
  input  logic [REG_AW-1:0] instRd,
  input  logic [REG_AW-1:0] instRs1,
  input  logic [REG_AW-1:0] instRs2,
  input  logic [DATA_W-1:0] instImm,
  output logic              fitsOk,
  output logic              needUpper,
  output logic              wbValid,
  output logic [REG_AW-1:0] wbRd,
  output logic [DATA_W-1:0] wbData
);
  logic              wbValidQ;
  logic [REG_AW-1:0] wbRdQ;
  logic [DATA_W-1:0] wbDataQ;
  widthE             wbTagQ;

  widthE             regTag [NREGS];
  logic [DATA_W-1:0] rawA, rawB;
  logic [NSLICES-1:0] sliceWe;

  logic [2:0]        repOp;
  logic [REG_AW-1:0] repRd;
  logic [DATA_W-1:0] repA, repB, repImm;

  for (genvar s = 0; s < NSLICES; s++) begin : g_slice
    logic [SLICE_W-1:0] mem [NREGS];
    if (s == 0) begin : g_low
      assign sliceWe[s] = 1'b1;
    end else if (s == 1) begin : g_mid
      assign sliceWe[s] = (wbTagQ != MODE8);
    end else begin : g_high
      assign sliceWe[s] = (wbTagQ == MODE32);
    end
    always_ff @(posedge clk) begin
      if (!rstN) begin
        for (int i = 0; i < NREGS; i++) mem[i] <= '0;
      end else if (wbValidQ && sliceWe[s]) begin
        mem[wbRdQ] <= wbDataQ[s*SLICE_W +: SLICE_W];
      end
    end
    assign rawA[s*SLICE_W +: SLICE_W] = mem[instRs1];
    assign rawB[s*SLICE_W +: SLICE_W] = mem[instRs2];
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int i = 0; i < NREGS; i++) regTag[i] <= MODE8;
    end else if (wbValidQ) begin
      regTag[wbRdQ] <= wbTagQ;
    end
  end

  logic [DATA_W-1:0] valA, valB, exRes, repRes;
  widthE tagA, tagB;
  logic  useA, useB, fwdA, fwdB;

  always_comb begin
    fwdA = wbValidQ && (wbRdQ == instRs1);
    fwdB = wbValidQ && (wbRdQ == instRs2);
    valA = fwdA ? wbDataQ : sextW(rawA, regTag[instRs1]);
    valB = fwdB ? wbDataQ : sextW(rawB, regTag[instRs2]);
    tagA = fwdA ? wbTagQ : regTag[instRs1];
    tagB = fwdB ? wbTagQ : regTag[instRs2];
    useA = (instOp != OP_IMM) && (instOp != OP_CFG);
    useB = (instOp <= OP_XOR);
    exRes  = aluF(instOp, valA, valB, instImm);
    repRes = aluF(repOp, repA, repB, repImm);
    fitsOk = (!useA || fitsW(valA, strobes.mode)) &&
             (!useB || fitsW(valB, strobes.mode)) &&
             fitsW(exRes, strobes.mode);
    needUpper = (useA && (tagA > strobes.mode)) || (useB && (tagB > strobes.mode));
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      wbValidQ <= 1'b0;
      wbRdQ    <= '0;
      wbDataQ  <= '0;
      wbTagQ   <= MODE32;
      repOp    <= OP_ADD;
      repRd    <= '0;
      repA     <= '0;
      repB     <= '0;
      repImm   <= '0;
    end else begin
      if (strobes.capture) begin
        repOp  <= instOp;
        repRd  <= instRd;
        repA   <= valA;
        repB   <= valB;
        repImm <= instImm;
      end
      if (strobes.exWrite) begin
        wbValidQ <= 1'b1;
        wbRdQ    <= instRd;
        wbDataQ  <= exRes;
        wbTagQ   <= strobes.mode;
      end else if (strobes.replayWrite) begin
        wbValidQ <= 1'b1;
        wbRdQ    <= repRd;
        wbDataQ  <= repRes;
        wbTagQ   <= MODE32;
      end else begin
        wbValidQ <= 1'b0;
      end
    end
  end

  assign wbValid = wbValidQ;
  assign wbRd    = wbRdQ;
  assign wbData  = wbDataQ;

  AST_NO_WB_AFTER_MIS: assert property (@(posedge clk) disable iff (!rstN)
    strobes.capture |=> !wbValidQ); // R5
  AST_REPLAY_WB: assert property (@(posedge clk) disable iff (!rstN)
    strobes.replayWrite |=> wbValidQ); // R6
  AST_WB_FITS_TAG: assert property (@(posedge clk) disable iff (!rstN)
    wbValidQ |-> fitsW(wbDataQ, wbTagQ)); // R9
endmodule

// File: rtl/nwExecTop.sv
module nwExecTop
  import nw_pkg::*;
#(
  parameter int PENALTY = 5,
  parameter int NREGS   = 16
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        instValid,
  input  logic [2:0]  instOp,
  input  logic [3:0]  instRd,
  input  logic [3:0]  instRs1,
  input  logic [3:0]  instRs2,
  input  logic [31:0] instImm,
  input  logic [1:0]  instCfg,
  output logic        instReady,
  output logic        flushReq,
  output logic        wbValid,
  output logic [3:0]  wbRd,
  output logic [31:0] wbData,
  output logic [3:0]  sliceEn,
  output logic [3:0]  rfDrowsy,
  output logic [1:0]  curMode
);
  strobeS strobes;
  logic   fitsOk, needUpper;

  nwCtrl #(.PENALTY(PENALTY)) u_ctrl (
    .clk(clk), .rstN(rstN), .instValid(instValid), .instOp(instOp), .instCfg(instCfg),
    .fitsOk(fitsOk), .needUpper(needUpper), .strobes(strobes), .instReady(instReady),
    .flushReq(flushReq), .curMode(curMode), .sliceEn(sliceEn), .rfDrowsy(rfDrowsy)
  );

  nwDatapath #(.NREGS(NREGS)) u_dp (
    .clk(clk), .rstN(rstN), .strobes(strobes), .instOp(instOp), .instRd(instRd),
    .instRs1(instRs1), .instRs2(instRs2), .instImm(instImm), .fitsOk(fitsOk),
    .needUpper(needUpper), .wbValid(wbValid), .wbRd(wbRd), .wbData(wbData)
  );

  AST_CFG_NO_WB: assert property (@(posedge clk) disable iff (!rstN)
    (instValid && instReady && instOp == OP_CFG) |=> !wbValid); // R2
endmodule

// File: tb/nwExecTop_tb.sv
module nwExecTop_tb;
  localparam int CLK_P = 10;
  localparam int PEN   = 7;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        instValid = 1'b0;
  logic [2:0]  instOp = '0;
  logic [3:0]  instRd = '0, instRs1 = '0, instRs2 = '0;
  logic [31:0] instImm = '0;
  logic [1:0]  instCfg = '0;
  logic        instReady, flushReq, wbValid;
  logic [3:0]  wbRd, sliceEn, rfDrowsy;
  logic [31:0] wbData;
  logic [1:0]  curMode;

  nwExecTop #(.PENALTY(PEN), .NREGS(16)) u_dut (
    .clk(clk), .rstN(rstN), .instValid(instValid), .instOp(instOp), .instRd(instRd),
    .instRs1(instRs1), .instRs2(instRs2), .instImm(instImm), .instCfg(instCfg),
    .instReady(instReady), .flushReq(flushReq), .wbValid(wbValid), .wbRd(wbRd),
    .wbData(wbData), .sliceEn(sliceEn), .rfDrowsy(rfDrowsy), .curMode(curMode)
  );

  always #(CLK_P/2) clk = ~clk;

  int compared = 0, mismatched = 0;
  int pOp[128], pRd[128], pA[128], pB[128], pImm[128], pCfg[128];
  int nInst = 0, readStart = 0;

  int mrf[16], mtag[16];
  int mMode, mCnt, mWbRd, mWbVal, mWbTag;
  bit mPen, mWoke, mWbV, mWbReplay;
  int rOp, rA, rB, rRd, rImm;

  task automatic add(int op, int rd, int a, int b, int imm, int cfg);
    pOp[nInst] = op; pRd[nInst] = rd; pA[nInst] = a; pB[nInst] = b;
    pImm[nInst] = imm; pCfg[nInst] = cfg; nInst++;
  endtask

  function automatic bit fitsB(int v, int m);
    int w;
    if (m >= 2) return 1'b1;
    w = 8 << m;
    return (v >= -(1 << (w-1))) && (v <= (1 << (w-1)) - 1);
  endfunction

  function automatic int aluB(int op, int a, int b, int imm);
    case (op)
      0: return a + b;
      1: return a - b;
      2: return a & b;
      3: return a | b;
      4: return a ^ b;
      5: return imm;
      default: return a;
    endcase
  endfunction

  task automatic chk(string req, string nm, int act, int exp);
    compared++;
    if (act != exp) begin
      mismatched++;
      $display("FAIL %s %s actual=%0h expected=%0h at %0t", req, nm, act, exp, $time);
    end
  endtask

  task automatic step(bit first, bit inRead);
    int sl, dr, a, b, ta, tb, res, op;
    bit v, isCfg, useA, useB, need, rdy, acc, fit, mis;
    string rq;
    v = instValid; op = instOp;
    sl = (mMode == 0) ? 1 : (mMode == 1) ? 3 : 15;
    dr = mWoke ? 0 : (~sl & 15);
    isCfg = (op == 7);
    useA = (op != 5) && (op != 7);
    useB = (op <= 4);
    a  = (mWbV && mWbRd == instRs1) ? mWbVal : mrf[instRs1];
    ta = (mWbV && mWbRd == instRs1) ? mWbTag : mtag[instRs1];
    b  = (mWbV && mWbRd == instRs2) ? mWbVal : mrf[instRs2];
    tb = (mWbV && mWbRd == instRs2) ? mWbTag : mtag[instRs2];
    need = !mPen && v && !isCfg && (mMode != 2) &&
           ((useA && ta > mMode) || (useB && tb > mMode)) && !mWoke;
    rdy = !mPen && !need;
    acc = v && rdy;
    res = aluB(op, a, b, instImm);
    fit = (!useA || fitsB(a, mMode)) && (!useB || fitsB(b, mMode)) && fitsB(res, mMode);
    mis = acc && !isCfg && (mMode != 2) && !fit;

    rq = first ? "R1" : (mPen ? "R6" : "R8");
    chk(rq, "instReady", instReady, rdy);
    rq = first ? "R1" : ((mMode == 2) ? "R10" : "R5");
    chk(rq, "flushReq", flushReq, mis);
    rq = first ? "R1" : (mWbReplay ? "R6" : (inRead ? "R9" : "R4"));
    chk(rq, "wbValid", wbValid, mWbV);
    if (mWbV) begin
      chk(rq, "wbRd", wbRd, mWbRd);
      chk(rq, "wbData", wbData, mWbVal);
    end
    chk(first ? "R1" : "R2", "sliceEn", sliceEn, sl);
    chk(first ? "R1" : "R3", "rfDrowsy", rfDrowsy, dr);
    chk(first ? "R1" : "R7", "curMode", curMode, mMode);

    if (mWbV) begin mrf[mWbRd] = mWbVal; mtag[mWbRd] = mWbTag; end
    mWbReplay = 1'b0;
    if (acc) mWoke = 1'b0; else if (need) mWoke = 1'b1;
    if (mPen) begin
      if (mCnt == 1) begin
        mPen = 1'b0;
        mWbV = 1'b1; mWbRd = rRd; mWbVal = aluB(rOp, rA, rB, rImm); mWbTag = 2;
        mWbReplay = 1'b1;
      end else begin
        mCnt--; mWbV = 1'b0;
      end
    end else if (mis) begin
      mPen = 1'b1; mCnt = PEN; mMode = 2; mWbV = 1'b0;
      rOp = op; rA = a; rB = b; rRd = instRd; rImm = instImm;
    end else if (acc && isCfg) begin
      mMode = (instCfg == 0) ? 0 : (instCfg == 1) ? 1 : 2;
      mWbV = 1'b0;
    end else if (acc) begin
      mWbV = 1'b1; mWbRd = instRd; mWbVal = res; mWbTag = mMode;
    end else begin
      mWbV = 1'b0;
    end
    lastAcc = acc;
  endtask

  bit lastAcc = 1'b0;
  int cycles = 0;
  bit done = 1'b0;

  initial begin
    // program: full-width setup, forwarding
    add(5, 1, 0, 0, 100, 0);
    add(5, 2, 0, 0, -3, 0);
    add(0, 3, 1, 2, 0, 0);
    add(1, 4, 2, 1, 0, 0);
    add(5, 5, 0, 0, 32'h12345678, 0);
    add(2, 6, 5, 1, 0, 0);
    // 8-bit region: wake on wide tag, then overflow misspeculation
    add(7, 0, 0, 0, 0, 0);
    add(0, 7, 1, 2, 0, 0);
    add(0, 8, 7, 7, 0, 0);
    add(0, 9, 7, 1, 0, 0);
    // 16-bit region
    add(7, 0, 0, 0, 0, 1);
    add(5, 10, 0, 0, 30000, 0);
    add(0, 11, 10, 10, 0, 0);
    add(7, 0, 0, 0, 0, 1);
    add(4, 12, 10, 2, 0, 0);
    add(5, 13, 0, 0, -32768, 0);
    add(1, 14, 13, 13, 0, 0);
    add(3, 15, 7, 13, 0, 0);
    // 8-bit region: immediate too wide, wide operand too wide
    add(7, 0, 0, 0, 0, 0);
    add(5, 1, 0, 0, 200, 0);
    add(7, 0, 0, 0, 0, 0);
    add(5, 3, 0, 0, -128, 0);
    add(0, 4, 3, 0, 0, 0);
    add(6, 2, 4, 0, 0, 0);
    add(0, 5, 5, 0, 0, 0);
    add(7, 0, 0, 0, 0, 3);
    add(0, 6, 3, 3, 0, 0);
    // readback of every register at full width
    readStart = nInst;
    for (int r = 1; r < 16; r++) add(3, r, r, r, 0, 0);
  end

  initial begin
    int idx, gap, tail;
    for (int i = 0; i < 16; i++) begin mrf[i] = 0; mtag[i] = 0; end
    mMode = 2; mPen = 0; mCnt = 0; mWoke = 0; mWbV = 0; mWbReplay = 0;
    mWbRd = 0; mWbVal = 0; mWbTag = 2;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    idx = 0; gap = 0; tail = 0;
    @(negedge clk);
    #1 step(1'b1, 1'b0);
    while (tail < 6) begin
      @(negedge clk);
      if (idx < nInst && gap == 0) begin
        instValid = 1'b1; instOp = 3'(pOp[idx]); instRd = 4'(pRd[idx]);
        instRs1 = 4'(pA[idx]); instRs2 = 4'(pB[idx]); instImm = pImm[idx];
        instCfg = 2'(pCfg[idx]);
      end else begin
        instValid = 1'b0;
      end
      #1 step(1'b0, idx > readStart);
      if (instValid && lastAcc) begin
        idx++;
        gap = (idx % 3 == 2) ? 1 : 0;
      end else if (!instValid && gap > 0) begin
        gap--;
      end
      if (idx >= nInst) tail++;
    end
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 5000 && !done) begin
      mismatched++;
      $display("FAIL watchdog R6 actual=%0d expected=<5000 cycles", cycles);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end
endmodule